// File: doc/BRIEF.md
# Asymmetric Phase-Accumulator Waveform Generator

This block makes one signed 16-bit waveform sample each time its sample strobe is high. It can produce a cosine, a square or a triangle wave. A 32-bit phase accumulator drives all three shapes. The step added to the accumulator comes from one of two tuning words, and the sign of the accumulator picks which one. Because of this, the negative and non-negative halves of each period advance at separate rates. A host uses this to set the duty cycle of the square and the slope balance of the triangle.

The waveform value is multiplied by a signed amplitude code, then rounded and scaled back to 16 bits. The result appears on a registered output with a one-cycle valid pulse. The host writes a new shape, amplitude and pair of tuning words through a load strobe. A load never disturbs the accumulator, so the phase stays continuous when settings change. The host converts frequency, symmetry and voltage into tuning words and amplitude codes before loading them.

Top module: `wavegen`

## Requirements
- R1: The accumulator is 32 bits wide and resets to 0. It changes only on a cycle with `strobe` high, and then it adds exactly one tuning word, wrapping modulo 2^32.
- R2: Bit 31 of the accumulator before the add selects the step. When the bit is 1, the step is `cfg_tw0`. When the bit is 0, the step is `cfg_tw1`.
- R3: Shape code 1 selects the square wave. After the add, the raw square value is +32767 when bit 31 of the accumulator is 1, and -32767 when it is 0. Shape code 3 gives a raw value of 0.
- R4: Shape code 2 selects the triangle wave. The raw value is 32767 minus floor(|p| / 2^15), where p is the accumulator read as signed after the add. Any result below -32767 is clamped to -32767.
- R5: Shape code 0 selects the cosine. Take i as the top 10 bits of the accumulator after the add, read unsigned. The raw value is round(32767 * cos(2*pi*(i + 0.5) / 1024)).
- R6: The output equals the low 16 bits of floor((raw * amp + 2^14) / 2^15). Here amp is the signed amplitude code and the product is signed.
- R7: `sample_valid` is high for exactly the one cycle that comes two clock edges after a cycle with `strobe` high. `sample_out` changes only together with `sample_valid`, and holds its value in between.
- R8: A cycle with `cfg_load` high captures the shape, both tuning words and the amplitude. The captured values apply from the next strobe cycle after that load. A strobe in the same cycle as a load still uses the old settings. A load never changes the accumulator.
- R9: If a tuning word equals 2^31, the half-period that uses it lasts exactly one sample.
- R10: After reset, `sample_out` is 0 and `sample_valid` is 0. All stored settings are 0, so until a load the samples are cosine samples with amplitude 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Take one sample this cycle |
| cfg_load | input | 1 | Capture the configuration inputs |
| cfg_shape | input | 2 | 0 cosine, 1 square, 2 triangle, 3 zero |
| cfg_tw0 | input | 32 | Step used while the accumulator is negative |
| cfg_tw1 | input | 32 | Step used while the accumulator is non-negative |
| cfg_amp | input | 16 | Signed amplitude code |
| sample_out | output | 16 | Signed scaled sample |
| sample_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
Most faults in the accumulator or in the tuning-word select stay visible at the ports. A wrong phase value or a wrong choice of step shows up in the next valid sample. That sample arrives two cycles after the strobe. The error does not go away afterwards, because the accumulator carries it into every later sample.

A wrong cosine table entry or a bad rounding step only shows up on the samples that reach that entry or that boundary. The bench therefore uses these three things:
- steps that walk through every table address;
- a negative amplitude;
- the full-scale amplitude.

Faults in the load path are caught the same way. If settings are latched on the wrong cycle, or the phase jumps during a load, the first sample after the load is wrong.

// File: rtl/wavegen.sv
module wavegen #(
  parameter int PHASE_W = 32,
  parameter int SMP_W   = 16,
  parameter int TAB_AW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic               cfg_load,
  input  logic [1:0]         cfg_shape,
  input  logic [PHASE_W-1:0] cfg_tw0,
  input  logic [PHASE_W-1:0] cfg_tw1,
  input  logic [SMP_W-1:0]   cfg_amp,
  output logic [SMP_W-1:0]   sample_out,
  output logic               sample_valid
);
  localparam int  TAB_N  = 1 << TAB_AW;
  localparam int  IDX_W  = TAB_AW + 2;
  localparam int  FULL   = (1 << (SMP_W - 1)) - 1;
  localparam int  TRI_SH = PHASE_W - SMP_W - 1;
  localparam int  PROD_W = 2 * SMP_W;
  localparam real PI     = 3.14159265358979323846;

  localparam logic [1:0] SH_COS = 2'd0;
  localparam logic [1:0] SH_SQR = 2'd1;
  localparam logic [1:0] SH_TRI = 2'd2;

  logic [PHASE_W-1:0]       tw0_q, tw1_q, acc_q;
  logic [1:0]               shape_q, shape_s1;
  logic signed [SMP_W-1:0]  amp_q, amp_s1;
  logic                     v1_q;
  logic [SMP_W-1:0]         out_q;
  logic                     valid_q;

  logic [SMP_W-2:0] qtab [TAB_N];

  initial begin
    for (int i = 0; i < TAB_N; i++) begin
      int v;
      v = $rtoi($floor(FULL * $cos(PI / 2.0 * (i + 0.5) / TAB_N) + 0.5));
      qtab[i] = v[SMP_W-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shape_q <= '0;
      tw0_q   <= '0;
      tw1_q   <= '0;
      amp_q   <= '0;
    end else if (cfg_load) begin
      shape_q <= cfg_shape;
      tw0_q   <= cfg_tw0;
      tw1_q   <= cfg_tw1;
      amp_q   <= $signed(cfg_amp);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      v1_q     <= 1'b0;
      shape_s1 <= '0;
      amp_s1   <= '0;
    end else begin
      v1_q <= strobe;
      if (strobe) begin
        acc_q    <= acc_q + (acc_q[PHASE_W-1] ? tw0_q : tw1_q);
        shape_s1 <= shape_q;
        amp_s1   <= amp_q;
      end
    end
  end

  // cosine from a quarter-wave table of mid-point samples
  logic [IDX_W-1:0]  idx;
  logic [1:0]        quad;
  logic [TAB_AW-1:0] taddr;
  logic [SMP_W-1:0]  cmag, cos_v;
  assign idx   = acc_q[PHASE_W-1 -: IDX_W];
  assign quad  = idx[IDX_W-1 -: 2];
  assign taddr = quad[0] ? ~idx[TAB_AW-1:0] : idx[TAB_AW-1:0];
  assign cmag  = {1'b0, qtab[taddr]};
  assign cos_v = (quad[1] ^ quad[0]) ? -cmag : cmag;

  // triangle from the magnitude of the signed phase
  logic [PHASE_W-1:0]       pmag, tsh;
  logic signed [PHASE_W:0]  full_w, tri_w;
  logic [SMP_W-1:0]         tri_v, sqr_v;
  assign pmag   = acc_q[PHASE_W-1] ? -acc_q : acc_q;
  assign tsh    = pmag >> TRI_SH;
  assign full_w = (PHASE_W+1)'(FULL);
  assign tri_w  = full_w - $signed({1'b0, tsh});
  assign tri_v  = (tri_w < -full_w) ? -SMP_W'(FULL) : tri_w[SMP_W-1:0];
  assign sqr_v  = acc_q[PHASE_W-1] ? SMP_W'(FULL) : -SMP_W'(FULL);

  logic signed [SMP_W-1:0]  raw;
  logic signed [PROD_W-1:0] prod, rnd;
  always_comb begin
    case (shape_s1)
      SH_COS:  raw = $signed(cos_v);
      SH_SQR:  raw = $signed(sqr_v);
      SH_TRI:  raw = $signed(tri_v);
      default: raw = '0;
    endcase
  end
  assign prod = raw * amp_s1;
  assign rnd  = (prod + PROD_W'(1 << (SMP_W - 2))) >>> (SMP_W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= v1_q;
      if (v1_q) out_q <= rnd[SMP_W-1:0];
    end
  end

  assign sample_out   = out_q;
  assign sample_valid = valid_q;

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(acc_q));

  assert_square_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && shape_s1 == SH_SQR) |-> (raw == FULL || raw == -FULL));

  assert_raw_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |-> (raw >= -FULL && raw <= FULL));

  assert_zero_amp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && amp_s1 == 0) |=> (sample_out == 0));

  assert_valid_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(strobe, 2));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> $stable(sample_out));
endmodule

// File: tb/sim_wavegen.sv
module sim_wavegen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0, cfg_load = 1'b0;
  logic [1:0]  cfg_shape = '0;
  logic [31:0] cfg_tw0 = '0, cfg_tw1 = '0;
  logic [15:0] cfg_amp = '0;
  logic [15:0] sample_out;
  logic        sample_valid;

  always #5 clk = ~clk;

  wavegen u0 (.clk(clk), .rst_n(rst_n), .strobe(strobe), .cfg_load(cfg_load),
    .cfg_shape(cfg_shape), .cfg_tw0(cfg_tw0), .cfg_tw1(cfg_tw1), .cfg_amp(cfg_amp),
    .sample_out(sample_out), .sample_valid(sample_valid));

  typedef struct { int due; logic [15:0] v; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [31:0] m_acc = '0, m_tw0 = '0, m_tw1 = '0;
  logic [1:0]  m_shape = '0;
  longint      m_amp = 0;
  logic [15:0] m_last = '0;
  string       cur_tag = "R10";

  function automatic longint m_raw(logic [1:0] sh, logic [31:0] a);
    longint p, m, t;
    int i;
    real v;
    p = longint'($signed(a));
    case (sh)
      2'd0: begin
        i = int'(a[31:22]);
        v = 32767.0 * $cos(2.0 * 3.14159265358979323846 * (i + 0.5) / 1024.0);
        return longint'($rtoi($floor(v + 0.5)));
      end
      2'd1: return (p < 0) ? 32767 : -32767;
      2'd2: begin
        m = (p < 0) ? -p : p;
        t = 32767 - (m >>> 15);
        return (t < -32767) ? -32767 : t;
      end
      default: return 0;
    endcase
  endfunction

  task automatic check(input logic ev, input logic [15:0] eval, input string tag);
    n_chk++;
    if (sample_valid !== ev || sample_out !== eval) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual valid=%0b out=%0d expected valid=%0b out=%0d",
        tag, cyc, sample_valid, $signed(sample_out), ev, $signed(eval));
    end
  endtask

  task automatic tick(input logic st, input logic ld, input logic [1:0] sh,
                      input logic [31:0] t0, input logic [31:0] t1, input logic [15:0] am);
    longint r;
    exp_t e;
    if (q.size() > 0 && q[0].due == cyc) begin
      m_last = q[0].v;
      check(1'b1, q[0].v, q[0].tag);
      void'(q.pop_front());
    end else check(1'b0, m_last, "R7 hold");
    if (st) begin
      m_acc = m_acc + (m_acc[31] ? m_tw0 : m_tw1);
      r = (m_raw(m_shape, m_acc) * m_amp + 16384) >>> 15;
      e.due = cyc + 2; e.v = r[15:0]; e.tag = cur_tag;
      q.push_back(e);
    end
    if (ld) begin
      m_shape = sh; m_tw0 = t0; m_tw1 = t1; m_amp = longint'($signed(am));
    end
    strobe = st; cfg_load = ld; cfg_shape = sh; cfg_tw0 = t0; cfg_tw1 = t1; cfg_amp = am;
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(1'b0, 1'b0, 2'd3, 32'hDEAD_BEEF, 32'h1234_5678, 16'h7FFF);
  endtask

  task automatic load(input logic [1:0] sh, input logic [31:0] t0, input logic [31:0] t1,
                      input logic [15:0] am);
    tick(1'b0, 1'b1, sh, t0, t1, am);
  endtask

  task automatic run(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      tick(1'b1, 1'b0, 2'd0, '0, '0, '0);
      if (gap > 0) idle(gap);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R10 reset";
    check(1'b0, 16'h0000, "R10 reset state");
    run(4, 0);
    idle(3);

    cur_tag = "R5 cosine R6";
    load(2'd0, 32'h0040_0000, 32'h0040_0000, 16'h7FFF);
    run(1030, 0);
    idle(3);

    cur_tag = "R2/R3 square asym";
    load(2'd1, 32'h0400_0000, 32'h0200_0000, 16'hB1E0);
    run(120, 1);
    idle(3);

    cur_tag = "R9 R4 triangle";
    load(2'd2, 32'h8000_0000, 32'h0123_4567, 16'd12345);
    run(300, 0);
    idle(3);

    cur_tag = "R1 wrap R4 R6";
    load(2'd2, 32'h7FFF_FFFF, 32'h7FFF_8001, 16'h8000);
    run(60, 0);
    idle(2);

    cur_tag = "R8 load with strobe";
    tick(1'b1, 1'b1, 2'd1, 32'h0111_1111, 32'h0333_3333, 16'd20000);
    run(10, 0);
    tick(1'b1, 1'b1, 2'd0, 32'h0050_0000, 32'h0010_0000, 16'hC000);
    run(400, 0);
    idle(4);

    cur_tag = "R3 zero shape";
    load(2'd3, 32'h0100_0000, 32'h0100_0000, 16'h7FFF);
    run(8, 2);

    cur_tag = "R9 R2 full duty";
    load(2'd1, 32'h0300_0000, 32'h8000_0000, 16'd9999);
    run(80, 0);
    idle(4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule